// File: doc/BRIEF.md
# Linear Frequency Sweep Generator

This block produces a tuning word that moves linearly over time. A programmable interval timer counts clock cycles. Each time it expires, a signed step value is added to a 32-bit offset register. The offset is added to a fixed base tuning word, and the sum feeds a downstream phase accumulator. When the sweep is turned off, the base word passes straight through to the output.

Two control bits act on the offset register, each in its own way:
- One bit clears it for a single cycle whenever the update strobe arrives.
- The other bit holds it at zero for as long as the bit stays high.

A third bit decides what the update strobe does to the interval timer. When it is set, the strobe restarts the full interval. When it is clear, the countdown carries on as if no strobe had come.

Top module: `freq_sweep_gen`

## Requirements
- R1: While `sweep_en_i` is 0, `ftw_o` equals `base_ftw_i` and the offset register does not step. When the sweep is enabled again, the output resumes at `base_ftw_i` plus the offset held from before.
- R2: With interval value N ≥ 1, the offset steps by `delta_i` once every N enabled clock edges. The first step falls on the N-th enabled edge after the timer was loaded while disabled. The offset changes in no other cycle.
- R3: An interval value of 0 behaves like 1, so the offset steps on every enabled edge.
- R4: With `reload_on_upd_i` = 0, a pulse on `upd_i` leaves the countdown undisturbed.
- R5: With `reload_on_upd_i` = 1, a pulse on `upd_i` reloads the timer with the interval value. The next step then comes a full interval after that edge.
- R6: With `autoclr_on_upd_i` = 1, an `upd_i` pulse zeroes the offset at that edge only, and stepping resumes on the next edge. With the bit at 0, `upd_i` has no effect on the offset.
- R7: While `clr_hold_i` is 1, the offset is zero and stays zero, even on edges where the timer expires. Stepping resumes after the bit falls.
- R8: A one-cycle clear caused by `upd_i` takes priority over a step in the same cycle.
- R9: `ftw_o` = `base_ftw_i` + offset, modulo 2^32. The step is two's complement, so a negative step wraps through zero.
- R10: After reset, the offset is 0 and, with the sweep disabled, `ftw_o` equals `base_ftw_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sweep_en_i | input | 1 | Sweep enable |
| rate_i | input | RATE_W | Step interval in clock cycles (0 treated as 1) |
| delta_i | input | FTW_W | Signed step added on each timer expiry |
| base_ftw_i | input | FTW_W | Base tuning word |
| reload_on_upd_i | input | 1 | Update strobe restarts the interval timer |
| autoclr_on_upd_i | input | 1 | Update strobe clears the offset for one cycle |
| clr_hold_i | input | 1 | Hold the offset at zero |
| upd_i | input | 1 | Update strobe, one cycle |
| ftw_o | output | FTW_W | Output tuning word |

## Verification
A timer expiry and a clear can land on the same edge. This is provoked with an interval of 1, which makes every enabled edge an expiry:
- With the update strobe and its auto-clear bit set in the same cycle, the output must drop to the base word rather than advance.
- With the held clear raised for several cycles, the output must stay at the base word throughout.

An update strobe arriving mid-countdown is the second collision. The cycle of the next step is compared with the reload control at 0 and at 1.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef struct packed {
    logic reload_on_upd;
    logic autoclr_on_upd;
    logic clr_hold;
  } sweep_ctrl_t;
endpackage

// File: rtl/fsg_rate_timer.sv
module fsg_rate_timer #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              reload_on_upd_i,
  input  logic              upd_i,
  output logic              tick_o,
  output logic [RATE_W-1:0] cnt_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [RATE_W-1:0] cnt_q, rate_eff;

  // zero interval behaves like one
  assign rate_eff = (rate_i == '0) ? ONE : rate_i;
  assign tick_o   = en_i && (cnt_q == ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= ONE;
    else if (!en_i)                    cnt_q <= rate_eff;
    else if (tick_o)                   cnt_q <= rate_eff;
    else if (upd_i && reload_on_upd_i) cnt_q <= rate_eff;
    else                               cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/fsg_offset_acc.sv
module fsg_offset_acc #(
  parameter int unsigned FTW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fsg_pkg::sweep_ctrl_t ctrl_i,
  input  logic              upd_i,
  input  logic              tick_i,
  input  logic [FTW_W-1:0]  delta_i,
  output logic [FTW_W-1:0]  acc_o
);
  logic [FTW_W-1:0] acc_q;
  logic             clr_now;

  assign clr_now = ctrl_i.clr_hold || (ctrl_i.autoclr_on_upd && upd_i);
  assign acc_o   = acc_q;

  // clears outrank the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_now) acc_q <= '0;
    else if (tick_i)  acc_q <= acc_q + delta_i;
  end
endmodule

// File: rtl/fsg_ftw_sum.sv
module fsg_ftw_sum #(
  parameter int unsigned FTW_W = 32
) (
  input  logic             en_i,
  input  logic [FTW_W-1:0] base_i,
  input  logic [FTW_W-1:0] acc_i,
  output logic [FTW_W-1:0] ftw_o
);
  assign ftw_o = base_i + (en_i ? acc_i : '0);
endmodule

// File: rtl/freq_sweep_gen.sv
module freq_sweep_gen #(
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sweep_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [FTW_W-1:0]  delta_i,
  input  logic [FTW_W-1:0]  base_ftw_i,
  input  logic              reload_on_upd_i,
  input  logic              autoclr_on_upd_i,
  input  logic              clr_hold_i,
  input  logic              upd_i,
  output logic [FTW_W-1:0]  ftw_o
);
  fsg_pkg::sweep_ctrl_t ctrl;
  logic                 tick;
  logic [RATE_W-1:0]    cnt;
  logic [FTW_W-1:0]     acc;

  assign ctrl = '{reload_on_upd: reload_on_upd_i,
                  autoclr_on_upd: autoclr_on_upd_i,
                  clr_hold: clr_hold_i};

  fsg_rate_timer #(.RATE_W(RATE_W)) i_timer (
    .clk_i, .rst_ni, .en_i(sweep_en_i), .rate_i,
    .reload_on_upd_i, .upd_i, .tick_o(tick), .cnt_o(cnt)
  );

  fsg_offset_acc #(.FTW_W(FTW_W)) i_acc (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .upd_i, .tick_i(tick),
    .delta_i, .acc_o(acc)
  );

  fsg_ftw_sum #(.FTW_W(FTW_W)) i_sum (
    .en_i(sweep_en_i), .base_i(base_ftw_i), .acc_i(acc), .ftw_o
  );
endmodule

// File: rtl/freq_sweep_gen_chk.sv
module freq_sweep_gen_chk #(
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned RATE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sweep_en_i,
  input logic [RATE_W-1:0] rate_i,
  input logic [FTW_W-1:0]  delta_i,
  input logic [FTW_W-1:0]  base_ftw_i,
  input logic              reload_on_upd_i,
  input logic              autoclr_on_upd_i,
  input logic              clr_hold_i,
  input logic              upd_i,
  input logic [FTW_W-1:0]  ftw_o,
  input logic              tick,
  input logic [RATE_W-1:0] cnt,
  input logic [FTW_W-1:0]  acc
);
  logic any_clr;
  logic [RATE_W-1:0] rate_eff;
  assign any_clr  = clr_hold_i || (autoclr_on_upd_i && upd_i);
  assign rate_eff = (rate_i == '0) ? RATE_W'(1) : rate_i;

  assert_disabled_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sweep_en_i |-> ftw_o == base_ftw_i);

  assert_step_only_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !any_clr) |=> $stable(acc));

  assert_timer_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != '0);

  assert_reload_on_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_en_i && reload_on_upd_i && upd_i) |=> cnt == $past(rate_eff));

  assert_hold_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hold_i |=> acc == '0);

  assert_autoclear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (autoclr_on_upd_i && upd_i) |=> acc == '0);

  assert_step_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !any_clr) |=> acc == $past(acc) + $past(delta_i));
endmodule

bind freq_sweep_gen freq_sweep_gen_chk #(.FTW_W(FTW_W), .RATE_W(RATE_W)) i_chk (.*);

// File: tb/test_freq_sweep_gen.sv
module test_freq_sweep_gen;
  localparam int FTW_W = 32;
  localparam int RATE_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sweep_en = 0, reload_on_upd = 0, autoclr_on_upd = 0, clr_hold = 0, upd = 0;
  logic [RATE_W-1:0] rate = '0;
  logic [FTW_W-1:0]  delta = '0, base = '0, ftw;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  freq_sweep_gen #(.FTW_W(FTW_W), .RATE_W(RATE_W)) i_freq_sweep_gen (
    .clk_i(clk), .rst_ni(rst_n), .sweep_en_i(sweep_en), .rate_i(rate),
    .delta_i(delta), .base_ftw_i(base), .reload_on_upd_i(reload_on_upd),
    .autoclr_on_upd_i(autoclr_on_upd), .clr_hold_i(clr_hold), .upd_i(upd),
    .ftw_o(ftw)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [FTW_W-1:0] exp);
    checks++;
    if (ftw !== exp) begin
      errors++;
      $display("FAIL %s ftw_o=%h expected %h", req, ftw, exp);
    end
  endtask

  // disable, clear offset, load interval
  task automatic prep(input logic [RATE_W-1:0] r, input logic [FTW_W-1:0] d);
    sweep_en = 0; rate = r; delta = d; clr_hold = 1;
    reload_on_upd = 0; autoclr_on_upd = 0; upd = 0;
    step(1);
    clr_hold = 0;
  endtask

  task automatic t_reset;
    base = 32'd1234;
    #1 chk("R10 reset", 32'd1234);
  endtask

  task automatic t_period;
    base = 32'd1000;
    prep(16'd3, 32'd10);
    sweep_en = 1;
    step(2); chk("R2 before first step", 32'd1000);
    step(1); chk("R2 first step", 32'd1010);
    step(2); chk("R2 no step mid interval", 32'd1010);
    step(1); chk("R2 second step", 32'd1020);
  endtask

  task automatic t_disabled;
    sweep_en = 0;
    #1 chk("R1 disabled passthru", 32'd1000);
    step(5); chk("R1 still base", 32'd1000);
    sweep_en = 1;
    #1 chk("R1 offset held", 32'd1020);
  endtask

  task automatic t_rate_zero;
    base = 32'd50;
    prep(16'd0, 32'd3);
    sweep_en = 1;
    step(1); chk("R3 rate 0 step 1", 32'd53);
    step(1); chk("R3 rate 0 step 2", 32'd56);
  endtask

  task automatic t_reload(input logic ctl);
    base = 32'd200;
    prep(16'd4, 32'd1);
    sweep_en = 1; reload_on_upd = ctl;
    step(2);
    upd = 1; step(1); upd = 0;
    if (!ctl) begin
      step(1); chk("R4 countdown unchanged", 32'd201);
    end else begin
      step(1); chk("R5 no step after restart", 32'd200);
      step(2); chk("R5 still waiting", 32'd200);
      step(1); chk("R5 full interval", 32'd201);
    end
    reload_on_upd = 0;
  endtask

  task automatic t_autoclr;
    base = 32'd100;
    prep(16'd1, 32'd5);
    sweep_en = 1;
    step(3); chk("R6 build offset", 32'd115);
    autoclr_on_upd = 1; upd = 1;
    step(1); chk("R8 clear beats step", 32'd100);
    upd = 0;
    step(1); chk("R6 one cycle only", 32'd105);
    autoclr_on_upd = 0; upd = 1;
    step(1); chk("R6 bit off no clear", 32'd110);
    upd = 0;
  endtask

  task automatic t_hold;
    base = 32'd100;
    clr_hold = 1;
    step(1); chk("R7 held clear", 32'd100);
    step(2); chk("R7 stays zero", 32'd100);
    clr_hold = 0;
    step(1); chk("R7 resume", 32'd105);
  endtask

  task automatic t_wrap;
    base = 32'h10;
    prep(16'd1, 32'hFFFF_FFE0);
    sweep_en = 1;
    step(1); chk("R9 wrap below zero", 32'hFFFF_FFF0);
    step(1); chk("R9 second negative step", 32'hFFFF_FFD0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_period();
    t_disabled();
    t_rate_zero();
    t_reload(1'b0);
    t_reload(1'b1);
    t_autoclr();
    t_hold();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule